// File: doc/BRIEF.md
# Mixed-Reset Register Bank

This block holds five 32-bit registers that software reads and writes over a simple single-cycle request port. Each register has two 16-bit halves, the low field and the high field. Each half has its own reset source. The reset sources differ in polarity, and some act at the clock edge while others act at once. The bank lets one CPU-visible block hold state that belongs to several reset domains: a low field can be cleared on its own without disturbing its neighbours. One shared reset reloads every high field at once.

The request port takes a strobe, a write flag, a byte address and write data. Every accepted request is acknowledged one cycle later. A read returns the addressed word in the same cycle as the acknowledge. The response registers have a reset of their own, separate from all field resets. The high field of the last register has no constant reset value. It captures a 16-bit input bus at the edge where its reset is applied, and holds that value afterwards.

Top module: `mrst_regbank`

## Requirements
- R1: After all resets have been applied, registers 0 to 3 read 0x5678_1234. Register 4 reads {captured init bus value, 0x1234}.
- R2: A write with a mapped address replaces all 32 bits of the addressed register at the clock edge that samples the request. Every request is answered with `rsp_ack` high in the following cycle. For a read, `rsp_rdata` then holds the register contents; for a write it holds zero.
- R3: A byte address is mapped only when bits [1:0] are zero and the word index (address >> 2) is below 5, which covers byte addresses 0x00, 0x04, 0x08, 0x0C and 0x10. A read of any other address returns zero with an acknowledge. A write to any other address changes no register.
- R4: `rst` is active-high and acts at the clock edge. It loads 0x1234 into the low field of register 0 and leaves every other field unchanged.
- R5: `fld_rst_hs` is active-high and acts at the clock edge. It loads 0x1234 into the low field of register 1 only.
- R6: `fld_rst_ha` is active-high and acts at once, with no clock edge. A pulse of about 1 ns between clock edges loads 0x1234 into the low field of register 2 only.
- R7: `fld_rst_ls_n` is active-low and acts at the clock edge. It loads 0x1234 into the low field of register 3 only.
- R8: `fld_rst_la_n` is active-low and acts at once. A 1 ns low pulse between clock edges loads 0x1234 into the low field of register 4 only.
- R9: `upper_rst` is active-high and acts at the clock edge. It loads 0x5678 into the high fields of registers 0 to 3. It loads the value on `upper_init` at that edge into the high field of register 4, which keeps that value when `upper_init` later changes. Low fields are unchanged.
- R10: A field reset that is active at the same edge as a write to its register wins for the field it controls. The other field of that register takes the write data.
- R11: `cpu_rst` clears `rsp_ack` and `rsp_rdata` and suppresses the acknowledge of a request sampled while it is high. It never alters register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high clocked reset of register 0 low field |
| cpu_rst | input | 1 | Active-high reset of the response registers |
| fld_rst_hs | input | 1 | Active-high clocked reset, register 1 low field |
| fld_rst_ha | input | 1 | Active-high immediate reset, register 2 low field |
| fld_rst_ls_n | input | 1 | Active-low clocked reset, register 3 low field |
| fld_rst_la_n | input | 1 | Active-low immediate reset, register 4 low field |
| upper_rst | input | 1 | Active-high clocked reset of all high fields |
| upper_init | input | 16 | Value loaded into register 4 high field on `upper_rst` |
| req | input | 1 | Request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Acknowledge, one cycle after a request |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ack` |

## Verification
The hardest case to reach from the ports is an immediate reset that never overlaps a clock edge. A field that only samples its reset at the edge would then miss the pulse entirely. The stimulus waits for a falling clock edge, raises the reset 0.5 ns later for 1 ns, and drops it well before the next rising edge. A read afterwards shows whether the field was cleared. The same-edge collision of a write with a field reset is also built on purpose, so that one half of the register must show the reset value and the other half the written data.

// File: rtl/mrst_pkg.sv
package mrst_pkg;

    localparam int DATA_W  = 32;
    localparam int FIELD_W = DATA_W / 2;
    localparam int NREG    = 5;
    localparam int ADDR_W  = 5;
    localparam int WIDX_W  = ADDR_W - 2;

    typedef enum logic [1:0] {
        RK_SYNC_HI  = 2'd0,
        RK_ASYNC_HI = 2'd1,
        RK_SYNC_LO  = 2'd2,
        RK_ASYNC_LO = 2'd3
    } rst_kind_e;

    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } reg_word_t;

    // Reset style of the low field in each register slot.
    function automatic rst_kind_e low_kind(input int idx);
        case (idx)
            2:       return RK_ASYNC_HI;
            3:       return RK_SYNC_LO;
            4:       return RK_ASYNC_LO;
            default: return RK_SYNC_HI;
        endcase
    endfunction

endpackage

// File: rtl/mrst_field.sv
module mrst_field
    import mrst_pkg::*;
#(
    parameter int        W    = 16,
    parameter rst_kind_e KIND = RK_SYNC_HI
) (
    input  logic         clk,
    input  logic         rst_in,
    input  logic [W-1:0] rst_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);

    generate
        if (KIND == RK_ASYNC_HI) begin : g_async_hi
            always_ff @(posedge clk or posedge rst_in) begin
                if (rst_in)     q <= rst_val;
                else if (wr_en) q <= wr_data;
            end
        end else if (KIND == RK_ASYNC_LO) begin : g_async_lo
            always_ff @(posedge clk or negedge rst_in) begin
                if (!rst_in)    q <= rst_val;
                else if (wr_en) q <= wr_data;
            end
        end else begin : g_sync
            logic rst_act;
            assign rst_act = (KIND == RK_SYNC_HI) ? rst_in : ~rst_in;
            always_ff @(posedge clk) begin
                if (rst_act)    q <= rst_val;
                else if (wr_en) q <= wr_data;
            end
        end
    endgenerate

endmodule

// File: rtl/mrst_rdmux.sv
module mrst_rdmux #(
    parameter int NREG   = 5,
    parameter int DATA_W = 32,
    parameter int WIDX_W = 3
) (
    input  logic [NREG*DATA_W-1:0] words,
    input  logic                   hit,
    input  logic [WIDX_W-1:0]      widx,
    output logic [DATA_W-1:0]      rd_word
);

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit && widx == WIDX_W'(i)) rd_word = words[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/mrst_cpu_port.sv
module mrst_cpu_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              cpu_rst,
    input  logic              req,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (cpu_rst) begin
            rsp_ack   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ack   <= req;
            rsp_rdata <= (req && !req_wr) ? rd_word : '0;
        end
    end

endmodule

// File: rtl/mrst_regbank.sv
module mrst_regbank
    import mrst_pkg::*;
#(
    parameter logic [FIELD_W-1:0] LOW_INIT  = 16'h1234,
    parameter logic [FIELD_W-1:0] HIGH_INIT = 16'h5678
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_rst,
    input  logic               fld_rst_hs,
    input  logic               fld_rst_ha,
    input  logic               fld_rst_ls_n,
    input  logic               fld_rst_la_n,
    input  logic               upper_rst,
    input  logic [FIELD_W-1:0] upper_init,
    input  logic               req,
    input  logic               req_wr,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_ack,
    output logic [DATA_W-1:0]  rsp_rdata
);

    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(NREG - 1);

    logic [WIDX_W-1:0]      widx;
    logic                   addr_hit;
    logic [NREG-1:0]        wr_hit;
    logic [NREG-1:0]        low_src;
    reg_word_t              bank_q [NREG];
    logic [NREG*DATA_W-1:0] bank_flat;
    logic [DATA_W-1:0]      rd_word;

    assign widx     = req_addr[ADDR_W-1:2];
    assign addr_hit = (req_addr[1:0] == 2'b00) && (widx <= LAST_IDX);
    assign low_src  = {fld_rst_la_n, fld_rst_ls_n, fld_rst_ha, fld_rst_hs, rst};

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            logic [FIELD_W-1:0] hi_init;

            if (g == NREG - 1) begin : g_live
                assign hi_init = upper_init;
            end else begin : g_const
                assign hi_init = HIGH_INIT;
            end

            assign wr_hit[g] = req && req_wr && addr_hit && (widx == WIDX_W'(g));

            mrst_field #(.W(FIELD_W), .KIND(low_kind(g))) u_lo (
                .clk     (clk),
                .rst_in  (low_src[g]),
                .rst_val (LOW_INIT),
                .wr_en   (wr_hit[g]),
                .wr_data (req_wdata[FIELD_W-1:0]),
                .q       (bank_q[g].lo)
            );

            mrst_field #(.W(FIELD_W), .KIND(RK_SYNC_HI)) u_hi (
                .clk     (clk),
                .rst_in  (upper_rst),
                .rst_val (hi_init),
                .wr_en   (wr_hit[g]),
                .wr_data (req_wdata[DATA_W-1:FIELD_W]),
                .q       (bank_q[g].hi)
            );

            assign bank_flat[g*DATA_W +: DATA_W] = bank_q[g];
        end
    endgenerate

    mrst_rdmux #(.NREG(NREG), .DATA_W(DATA_W), .WIDX_W(WIDX_W)) u_rdmux (
        .words   (bank_flat),
        .hit     (addr_hit),
        .widx    (widx),
        .rd_word (rd_word)
    );

    mrst_cpu_port #(.DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .cpu_rst   (cpu_rst),
        .req       (req),
        .req_wr    (req_wr),
        .rd_word   (rd_word),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/mrst_regbank_chk.sv
module mrst_regbank_chk
    import mrst_pkg::*;
(
    input logic                   clk,
    input logic                   cpu_rst,
    input logic                   rst,
    input logic                   fld_rst_hs,
    input logic                   fld_rst_ha,
    input logic                   fld_rst_ls_n,
    input logic                   fld_rst_la_n,
    input logic                   upper_rst,
    input logic [FIELD_W-1:0]     upper_init,
    input logic                   req,
    input logic                   req_wr,
    input logic [ADDR_W-1:0]      req_addr,
    input logic                   rsp_ack,
    input logic [DATA_W-1:0]      rsp_rdata,
    input logic [NREG*DATA_W-1:0] bank_q
);

    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(NREG - 1);

    logic unmapped;
    assign unmapped = (req_addr[1:0] != 2'b00) || (req_addr[ADDR_W-1:2] > LAST_IDX);

    p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (cpu_rst)
        req |=> rsp_ack);

    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (cpu_rst)
        (req && !req_wr && unmapped) |=> (rsp_rdata == '0));

    p_glob_low0_r4: assert property (@(posedge clk) disable iff (cpu_rst)
        rst |=> (bank_q[0 +: FIELD_W] == 16'h1234));

    p_glob_isolated_r4: assert property (@(posedge clk) disable iff (cpu_rst)
        (rst && !fld_rst_hs && !upper_rst && !req) |=> $stable(bank_q[DATA_W +: DATA_W]));

    p_sync_hi_r5: assert property (@(posedge clk) disable iff (cpu_rst)
        fld_rst_hs |=> (bank_q[DATA_W +: FIELD_W] == 16'h1234));

    p_async_hi_r6: assert property (@(posedge clk) disable iff (cpu_rst)
        fld_rst_ha |-> (bank_q[2*DATA_W +: FIELD_W] == 16'h1234));

    p_sync_lo_r7: assert property (@(posedge clk) disable iff (cpu_rst)
        !fld_rst_ls_n |=> (bank_q[3*DATA_W +: FIELD_W] == 16'h1234));

    p_async_lo_r8: assert property (@(posedge clk) disable iff (cpu_rst)
        !fld_rst_la_n |-> (bank_q[4*DATA_W +: FIELD_W] == 16'h1234));

    p_upper_r9: assert property (@(posedge clk) disable iff (cpu_rst)
        upper_rst |=> ((bank_q[FIELD_W +: FIELD_W] == 16'h5678) &&
                       (bank_q[4*DATA_W+FIELD_W +: FIELD_W] == $past(upper_init))));

    p_cpu_quiet_r11: assert property (@(posedge clk)
        cpu_rst |=> (!rsp_ack && rsp_rdata == '0));

endmodule

bind mrst_regbank mrst_regbank_chk u_chk (
    .clk          (clk),
    .cpu_rst      (cpu_rst),
    .rst          (rst),
    .fld_rst_hs   (fld_rst_hs),
    .fld_rst_ha   (fld_rst_ha),
    .fld_rst_ls_n (fld_rst_ls_n),
    .fld_rst_la_n (fld_rst_la_n),
    .upper_rst    (upper_rst),
    .upper_init   (upper_init),
    .req          (req),
    .req_wr       (req_wr),
    .req_addr     (req_addr),
    .rsp_ack      (rsp_ack),
    .rsp_rdata    (rsp_rdata),
    .bank_q       (bank_flat)
);

// File: tb/mrst_regbank_tb.sv
`timescale 1ns/1ps
module mrst_regbank_tb;

    logic        clk = 1'b0;
    logic        rst, cpu_rst, fld_rst_hs, fld_rst_ha, fld_rst_ls_n, fld_rst_la_n, upper_rst;
    logic [15:0] upper_init;
    logic        req, req_wr;
    logic [4:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_ack;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mdl [5];

    always #2.5 clk = ~clk;

    mrst_regbank u_dut (
        .clk(clk), .rst(rst), .cpu_rst(cpu_rst),
        .fld_rst_hs(fld_rst_hs), .fld_rst_ha(fld_rst_ha),
        .fld_rst_ls_n(fld_rst_ls_n), .fld_rst_la_n(fld_rst_la_n),
        .upper_rst(upper_rst), .upper_init(upper_init),
        .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [4:0] a, input string tag, input logic [31:0] exp);
        req = 1'b1; req_wr = 1'b0; req_addr = a;
        @(negedge clk);
        req = 1'b0;
        check({tag, " ack"}, {31'd0, rsp_ack}, 32'd1);
        check(tag, rsp_rdata, exp);
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        req = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0; req_wr = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 5; i++) do_read(5'(i * 4), tag, mdl[i]);
    endtask

    task automatic t_reset_state();
        check("R11 ack idle after reset", {31'd0, rsp_ack}, 32'd0);
        check("R11 rdata idle after reset", rsp_rdata, 32'd0);
        check_all("R1 reset values");
    endtask

    task automatic t_write_read();
        for (int i = 0; i < 5; i++) begin
            mdl[i] = 32'hA000_0001 + 32'h0101_0101 * i;
            do_write(5'(i * 4), mdl[i]);
        end
        check_all("R2 write readback");
    endtask

    task automatic t_unmapped();
        do_read(5'h14, "R3 read 0x14", 32'd0);
        do_read(5'h1C, "R3 read 0x1C", 32'd0);
        do_read(5'h06, "R3 read misaligned 0x06", 32'd0);
        do_write(5'h18, 32'hDEAD_BEEF);
        do_write(5'h05, 32'hDEAD_BEEF);
        check_all("R3 unmapped writes ignored");
    endtask

    task automatic t_sync_pulse(input int which, input string tag);
        case (which)
            0: rst = 1'b1;
            1: fld_rst_hs = 1'b1;
            default: fld_rst_ls_n = 1'b0;
        endcase
        @(negedge clk);
        rst = 1'b0; fld_rst_hs = 1'b0; fld_rst_ls_n = 1'b1;
        mdl[which == 2 ? 3 : which][15:0] = 16'h1234;
        check_all(tag);
    endtask

    task automatic t_async_pulse(input bit hi, input string tag);
        @(negedge clk);
        #0.5;
        if (hi) fld_rst_ha = 1'b1; else fld_rst_la_n = 1'b0;
        #1.0;
        fld_rst_ha = 1'b0; fld_rst_la_n = 1'b1;
        @(negedge clk);
        mdl[hi ? 2 : 4][15:0] = 16'h1234;
        check_all(tag);
    endtask

    task automatic t_upper();
        upper_init = 16'h0F0F;
        upper_rst  = 1'b1;
        @(negedge clk);
        upper_rst  = 1'b0;
        upper_init = 16'hAAAA;
        for (int i = 0; i < 4; i++) mdl[i][31:16] = 16'h5678;
        mdl[4][31:16] = 16'h0F0F;
        check_all("R9 shared high reset, captured init");
    endtask

    task automatic t_priority();
        req = 1'b1; req_wr = 1'b1; req_addr = 5'h04; req_wdata = 32'hFFFF_EEEE;
        fld_rst_hs = 1'b1;
        @(negedge clk);
        req = 1'b0; req_wr = 1'b0; fld_rst_hs = 1'b0;
        mdl[1] = 32'hFFFF_1234;
        req = 1'b1; req_wr = 1'b1; req_addr = 5'h0C; req_wdata = 32'h1111_2222;
        upper_rst = 1'b1; upper_init = 16'h4444;
        @(negedge clk);
        req = 1'b0; req_wr = 1'b0; upper_rst = 1'b0;
        for (int i = 0; i < 4; i++) mdl[i][31:16] = 16'h5678;
        mdl[4][31:16] = 16'h4444;
        mdl[3][15:0]  = 16'h2222;
        check_all("R10 reset beats write");
    endtask

    task automatic t_cpu_rst();
        cpu_rst = 1'b1;
        req = 1'b1; req_wr = 1'b0; req_addr = 5'h08;
        @(negedge clk);
        req = 1'b0;
        check("R11 no ack under cpu reset", {31'd0, rsp_ack}, 32'd0);
        check("R11 rdata zero under cpu reset", rsp_rdata, 32'd0);
        cpu_rst = 1'b0;
        @(negedge clk);
        check_all("R11 contents kept");
    endtask

    initial begin
        rst = 1'b1; cpu_rst = 1'b1; fld_rst_hs = 1'b1; fld_rst_ha = 1'b1;
        fld_rst_ls_n = 1'b0; fld_rst_la_n = 1'b0; upper_rst = 1'b1;
        upper_init = 16'hC3A5;
        req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
        for (int i = 0; i < 4; i++) mdl[i] = 32'h5678_1234;
        mdl[4] = 32'hC3A5_1234;
        repeat (3) @(negedge clk);
        rst = 1'b0; cpu_rst = 1'b0; fld_rst_hs = 1'b0; fld_rst_ha = 1'b0;
        fld_rst_ls_n = 1'b1; fld_rst_la_n = 1'b1; upper_rst = 1'b0;
        upper_init = 16'h9999;
        @(negedge clk);
        t_reset_state();
        t_write_read();
        t_unmapped();
        t_sync_pulse(0, "R4 global reset low0 only");
        t_sync_pulse(1, "R5 hi sync reset");
        t_async_pulse(1'b1, "R6 hi immediate reset");
        t_sync_pulse(2, "R7 lo sync reset");
        t_async_pulse(1'b0, "R8 lo immediate reset");
        t_upper();
        t_priority();
        t_cpu_rst();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule